// File: doc/BRIEF.md
# Slow Timekeeping Tick Selector

This block makes the slow tick that paces a timekeeping counter. The tick is a single-cycle enable pulse in the system clock domain. It comes from one of two sources. The first is a fast internal RC oscillator tick, divided first by a fixed prescaler and then by a programmable factor. The second is an external low-frequency oscillator tick, used as it arrives. Both oscillators reach the block as one-cycle strobes synchronous to the system clock.

Software programs the block through a simple synchronous register bus with four word registers. Writes to the control register are guarded: they take effect only when the upper half-word of the write data holds a fixed key. While the external source is selected, a watchdog counts divided internal ticks. If no external tick arrives within a programmable number of them, the block drops back to the internal source by itself, unless software has disabled that fallback. A separate gate bit lets a copy of the selected tick out on a second output.

Top module: `slowclk_sel`

## Requirements
- R1: A write to register 0 (control) loads its bits only when write data bits 31:16 equal 0x16AA. Any other write there leaves the control register unchanged. Control reads back as bit 15 = fallback bypass, bit 4 = external oscillator enable, bit 0 = source select, with all other bits zero.
- R2: With control bit 0 at 0, `slow_tick` pulses one cycle after each divided internal tick. With bit 0 at 1, `slow_tick` pulses one cycle after each `ext_tick`.
- R3: The internal path divides `rc_tick` strobes by FIX_DIV and then by (P+1), where P is register 1 bits 4:0.
- R4: With bit 0 = 1, bit 15 = 0 and a non-zero window W in register 3, bit 0 is cleared by hardware after W divided internal ticks pass with no `ext_tick`. The tick then comes from the internal path. Bit 4 is kept.
- R5: With control bit 15 set, a silent external source never clears bit 0.
- R6: Each `ext_tick` restarts the failure window, so an external source that ticks more often than the window stays selected.
- R7: Register 2 bit 0 gates the output copy. `slow_out` equals `slow_tick` when that bit is 1 and stays 0 when it is 0.
- R8: After reset, control reads 0, P reads 0, gate reads 0 and the window reads WIN_RST.
- R9: A window value of 0 disables the failure detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_tick | input | 1 | Internal RC oscillator strobe |
| ext_tick | input | 1 | External oscillator strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| slow_tick | output | 1 | Selected slow tick enable |
| slow_out | output | 1 | Gated copy of the slow tick |

## Verification
The assertions assume that `rc_tick` and `ext_tick` are one-cycle strobes that are stable across the sampling edge. They also assume that a bus write lasts exactly one cycle with its address and data held for that cycle. The bench changes every input on the falling clock edge and issues each write as a single-cycle pulse. It keeps the window and divider values fixed while a failure window is being measured, so the fallback cycle is well defined. An external source that is stopped outright, or that ticks comfortably inside the window, keeps each outcome unambiguous.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;
  localparam int          REG_W    = 32;
  localparam logic [15:0] CTRL_KEY = 16'h16AA;
  localparam int          BIT_SEL  = 0;
  localparam int          BIT_EXT  = 4;
  localparam int          BIT_BYP  = 15;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DIV  = 2'd1,
    REG_GATE = 2'd2,
    REG_WIN  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic byp;
    logic ext_en;
    logic sel;
  } ctrl_t;
endpackage

// File: rtl/slowclk_rcdiv.sv
module slowclk_rcdiv #(
  parameter int FIX_DIV = 32,
  parameter int PW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rc_tick,
  input  logic [PW-1:0] div_p,
  output logic          int_tick
);
  localparam int CW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

  logic          pre_tick;
  logic [PW-1:0] c2_q, c2_d;

  generate
    if (FIX_DIV > 1) begin : g_fix
      logic [CW-1:0] c1_q, c1_d;
      logic          c1_last;
      assign c1_last  = (c1_q == CW'(FIX_DIV - 1));
      assign pre_tick = rc_tick && c1_last;

      always_comb begin
        c1_d = c1_q;
        if (rc_tick) c1_d = c1_last ? '0 : c1_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c1_q <= '0;
        else        c1_q <= c1_d;
      end

      assert_fix_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c1_q <= CW'(FIX_DIV - 1));
    end else begin : g_nofix
      assign pre_tick = rc_tick;
    end
  endgenerate

  always_comb begin
    c2_d = c2_q;
    if (pre_tick) c2_d = (c2_q >= div_p) ? '0 : c2_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c2_q <= '0;
    else        c2_q <= c2_d;
  end

  assign int_tick = pre_tick && (c2_q >= div_p);

  assert_tick_needs_rc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_tick |-> rc_tick);
endmodule

// File: rtl/slowclk_watch.sv
module slowclk_watch #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_tick,
  input  logic             ext_tick,
  input  logic             sel,
  input  logic             byp,
  input  logic [WIN_W-1:0] win,
  output logic             fail
);
  logic             mon;
  logic [WIN_W-1:0] cnt_q, cnt_d;

  assign mon  = sel && !byp && (win != '0);
  assign fail = mon && int_tick && !ext_tick && (cnt_q >= win - WIN_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!mon || ext_tick || fail) cnt_d = '0;
    else if (int_tick)            cnt_d = cnt_q + WIN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_no_fail_on_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |-> !fail);
  assert_zero_win_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win == '0) |-> !fail);
endmodule

// File: rtl/slowclk_regs.sv
module slowclk_regs
  import slowclk_pkg::*;
#(
  parameter int PW      = 5,
  parameter int WIN_W   = 8,
  parameter int WIN_RST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             fail,
  output ctrl_t            ctrl,
  output logic [PW-1:0]    div_p,
  output logic             gate,
  output logic [WIN_W-1:0] win,
  output logic [REG_W-1:0] bus_rdata
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [PW-1:0]    div_q, div_d;
  logic             gate_q, gate_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             ctrl_hit, key_ok, key_wr;

  assign ctrl_hit = bus_we && (bus_addr == REG_CTRL);
  assign key_ok   = (bus_wdata[REG_W-1:16] == CTRL_KEY);
  assign key_wr   = ctrl_hit && key_ok;

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    gate_d = gate_q;
    win_d  = win_q;
    if (key_wr) begin
      ctrl_d.sel    = bus_wdata[BIT_SEL];
      ctrl_d.ext_en = bus_wdata[BIT_EXT];
      ctrl_d.byp    = bus_wdata[BIT_BYP];
    end
    if (bus_we && bus_addr == REG_DIV)  div_d  = bus_wdata[PW-1:0];
    if (bus_we && bus_addr == REG_GATE) gate_d = bus_wdata[0];
    if (bus_we && bus_addr == REG_WIN)  win_d  = bus_wdata[WIN_W-1:0];
    if (fail) ctrl_d.sel = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      gate_q <= 1'b0;
      win_q  <= WIN_W'(WIN_RST);
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      gate_q <= gate_d;
      win_q  <= win_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: begin
        bus_rdata[BIT_SEL] = ctrl_q.sel;
        bus_rdata[BIT_EXT] = ctrl_q.ext_en;
        bus_rdata[BIT_BYP] = ctrl_q.byp;
      end
      REG_DIV:  bus_rdata[PW-1:0]    = div_q;
      REG_GATE: bus_rdata[0]         = gate_q;
      default:  bus_rdata[WIN_W-1:0] = win_q;
    endcase
  end

  assign ctrl  = ctrl_q;
  assign div_p = div_q;
  assign gate  = gate_q;
  assign win   = win_q;

  assert_keyless_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && !key_ok && !fail) |=> $stable(ctrl_q));
  assert_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !ctrl_q.sel);
  assert_bypass_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.sel && ctrl_q.byp && !key_wr) |=> ctrl_q.sel);
endmodule

// File: rtl/slowclk_sel.sv
module slowclk_sel
  import slowclk_pkg::*;
#(
  parameter int FIX_DIV = 32,
  parameter int PW      = 5,
  parameter int WIN_W   = 8,
  parameter int WIN_RST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rc_tick,
  input  logic             ext_tick,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             slow_tick,
  output logic             slow_out
);
  ctrl_t            ctrl;
  logic [PW-1:0]    div_p;
  logic             gate;
  logic [WIN_W-1:0] win;
  logic             int_tick, fail, src_tick;
  logic             tick_q, tick_d, out_q, out_d;

  slowclk_regs #(.PW(PW), .WIN_W(WIN_W), .WIN_RST(WIN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .fail(fail), .ctrl(ctrl), .div_p(div_p),
    .gate(gate), .win(win), .bus_rdata(bus_rdata)
  );

  slowclk_rcdiv #(.FIX_DIV(FIX_DIV), .PW(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .rc_tick(rc_tick), .div_p(div_p),
    .int_tick(int_tick)
  );

  slowclk_watch #(.WIN_W(WIN_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_tick(ext_tick),
    .sel(ctrl.sel), .byp(ctrl.byp), .win(win), .fail(fail)
  );

  assign src_tick = ctrl.sel ? ext_tick : int_tick;

  always_comb begin
    tick_d = src_tick;
    out_d  = src_tick && gate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      out_q  <= out_d;
    end
  end

  assign slow_tick = tick_q;
  assign slow_out  = out_q;

  assert_internal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.sel && !int_tick) |=> !slow_tick);
  assert_external_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.sel && ext_tick) |=> slow_tick);
  assert_gate_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slow_out |-> slow_tick);
  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> !slow_out);
endmodule

// File: tb/slowclk_sel_test.sv
module slowclk_sel_test;
  localparam int F     = 4;
  localparam int WRST  = 16;
  localparam logic [31:0] KEY = 32'h16AA_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rc_tick = 1'b0, ext_tick = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        slow_tick, slow_out;

  int nvec = 0, nbad = 0;
  string tag = "R8";
  bit running = 0;
  int rc_mode = 0, ext_period = 0, ext_cnt = 0;

  slowclk_sel #(.FIX_DIV(F), .PW(5), .WIN_W(8), .WIN_RST(WRST)) uut (
    .clk(clk), .rst_n(rst_n), .rc_tick(rc_tick), .ext_tick(ext_tick),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .slow_tick(slow_tick), .slow_out(slow_out)
  );

  always #4 clk = ~clk;

  // behavioural reference
  int m_c1, m_c2, m_p, m_win, m_mcnt;
  bit m_sel, m_en, m_byp, m_gate, m_slow, m_out;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c1 = 0; m_c2 = 0; m_p = 0; m_win = WRST; m_mcnt = 0;
      m_sel = 0; m_en = 0; m_byp = 0; m_gate = 0; m_slow = 0; m_out = 0;
    end else begin
      bit pre, it, mon, fl;
      pre = rc_tick && (m_c1 == F - 1);
      if (rc_tick) m_c1 = (m_c1 == F - 1) ? 0 : m_c1 + 1;
      it = pre && (m_c2 >= m_p);
      if (pre) m_c2 = (m_c2 >= m_p) ? 0 : m_c2 + 1;
      mon = m_sel && !m_byp && (m_win != 0);
      fl  = mon && it && !ext_tick && (m_mcnt >= m_win - 1);
      if (!mon || ext_tick || fl) m_mcnt = 0;
      else if (it) m_mcnt = m_mcnt + 1;
      m_slow = m_sel ? ext_tick : it;
      m_out  = m_slow && m_gate;
      if (bus_we) begin
        case (bus_addr)
          2'd0: if (bus_wdata[31:16] == 16'h16AA) begin
                  m_sel = bus_wdata[0]; m_en = bus_wdata[4]; m_byp = bus_wdata[15];
                end
          2'd1: m_p = bus_wdata[4:0];
          2'd2: m_gate = bus_wdata[0];
          default: m_win = bus_wdata[7:0];
        endcase
      end
      if (fl) m_sel = 0;
    end
  end

  // input generators
  always @(negedge clk) begin
    rc_tick <= (rc_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
    if (ext_period == 0) ext_tick <= 1'b0;
    else begin
      ext_tick <= (ext_cnt == 0);
      ext_cnt  <= (ext_cnt + 1) % ext_period;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (running) begin
      nvec++;
      if (slow_tick !== m_slow || slow_out !== m_out) begin
        nbad++;
        $display("FAIL %s tick/out got %b/%b exp %b/%b at %0t",
                 tag, slow_tick, slow_out, m_slow, m_out, $time);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string rq);
    @(negedge clk); bus_addr = a; #1;
    nvec++;
    if (bus_rdata !== exp) begin
      nbad++;
      $display("FAIL %s read addr %0d got %h exp %h", rq, a, bus_rdata, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    // R8 reset values
    rd(2'd0, 32'h0, "R8"); rd(2'd1, 32'h0, "R8");
    rd(2'd2, 32'h0, "R8"); rd(2'd3, WRST, "R8");
    // R3 / R2 internal division
    tag = "R3"; run(40);
    wr(2'd1, 32'd2); rd(2'd1, 32'd2, "R3"); run(60);
    rc_mode = 1; run(80); rc_mode = 0;
    // R1 key protection
    tag = "R1";
    wr(2'd0, 32'h0000_8011); rd(2'd0, 32'h0, "R1");
    wr(2'd0, 32'h16AB_0011); rd(2'd0, 32'h0, "R1");
    // R2 external source, R7 gate
    tag = "R2"; ext_period = 5;
    wr(2'd0, KEY | 32'h11); rd(2'd0, 32'h11, "R1"); run(40);
    tag = "R7"; wr(2'd2, 32'd1); rd(2'd2, 32'd1, "R7"); run(30);
    wr(2'd2, 32'd0); run(30);
    wr(2'd2, 32'd1);
    // R4 fallback
    tag = "R4"; wr(2'd3, 32'd3); ext_period = 0; run(60);
    rd(2'd0, 32'h10, "R4"); run(30);
    // R5 bypass
    tag = "R5"; wr(2'd0, KEY | 32'h8011); run(120);
    rd(2'd0, 32'h8011, "R5");
    // R9 window zero
    tag = "R9"; wr(2'd3, 32'd0); wr(2'd0, KEY | 32'h11); run(120);
    rd(2'd0, 32'h11, "R9");
    // R6 ext restarts window
    tag = "R6"; ext_cnt = 0; ext_period = 20; wr(2'd3, 32'd3); run(200);
    rd(2'd0, 32'h11, "R6");
    ext_period = 0; run(60); rd(2'd0, 32'h10, "R4");
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule